// File: doc/BRIEF.md
# Sector Write-Protection Arbiter

This block sits between the command logic of a sixteen-sector flash array and the erase and program engine. Each program or sector-erase request carries a 20-bit byte address. The arbiter finds the 64-Kbyte sector that the address falls in. It then answers the request with exactly one grant or one reject, one clock later. The answer combines four things: two hardware protect pins, a software write-lock bit for each sector, the two reset inputs, and two supply-lockout flags that the analog detectors deliver as digital levels.

The arbiter also owns the per-sector lock register file. Each sector has a write-lock bit and a read-lock bit. A lock write is refused while an erase or program is running. A read aimed at a read-locked sector returns zero and does not strobe the array. Every rejected request raises a sticky protection-error flag. That flag stays set until a clear-status command arrives.

One pin guards only the top sector (sector 15). The other pin guards sectors 0 to 14. The pins and the lock bits protect independently: releasing a pin never releases a register lock.

Top module: `sector_guard`

## Requirements
- R1: The sector of an address is its bits 19:16. A request is judged only by the lock state and pin of that sector, so a lock on sector N affects no address outside N.
- R2: While topLockN is 0, every request aimed at sector 15 is rejected, whatever that sector's lock bits hold.
- R3: While wpN is 0, every request aimed at sectors 0 to 14 is rejected, whatever their lock bits hold.
- R4: With both pins at 1, a sector whose write-lock bit (lock bit 0) is 1 still rejects requests. Changing the pins never changes the contents of any lock register.
- R5: While vppLow or vccLockout is 1, every request is rejected.
- R6: While rstN or initN is 0, all lock registers read 0 (unlocked), protErr is 0, no grant or reject is issued, and lock writes have no effect.
- R7: A lock write (lockWrEn) is ignored while busy is 1. Otherwise it loads lockWrData into the addressed sector on the next clock edge.
- R8: For every request (reqValid at a clock edge), exactly one of reqGrant and reqReject is 1 during the following cycle. Both are 0 in cycles that follow no request.
- R9: A rejected request sets protErr at the same edge as reqReject. protErr then stays 1 until clrStatus is sampled. If a reject and a clear occur in the same cycle, the set wins.
- R10: A read whose sector has its read-lock bit (lock bit 1) at 1 returns rdData = 0x00 and holds arrayRdEn at 0. Otherwise arrayRdEn follows rdValid and rdData passes arrayData.
- R11: lockRdData shows the lock register of sector lockRdSector combinationally: bit 0 is write-lock, bit 1 is read-lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Interface reset, active low |
| initN | input | 1 | Processor reset, active low, combined with rstN |
| topLockN | input | 1 | Top-sector hardware lock pin, 0 protects sector 15 |
| wpN | input | 1 | Write-protect pin, 0 protects sectors 0 to 14 |
| vppLow | input | 1 | Programming supply below lockout level |
| vccLockout | input | 1 | Core supply below lockout level |
| busy | input | 1 | Program or erase operation running |
| reqValid | input | 1 | Program or erase request strobe |
| reqAddr | input | 20 | Byte address of the request |
| reqGrant | output | 1 | Request allowed (cycle after request) |
| reqReject | output | 1 | Request refused (cycle after request) |
| lockWrEn | input | 1 | Lock register write strobe |
| lockWrSector | input | 4 | Sector whose lock register is written |
| lockWrData | input | 2 | New lock bits: bit 0 write-lock, bit 1 read-lock |
| lockRdSector | input | 4 | Sector whose lock register is shown |
| lockRdData | output | 2 | Lock bits of lockRdSector |
| clrStatus | input | 1 | Clear-status command |
| protErr | output | 1 | Sticky protection-error flag |
| rdValid | input | 1 | Array read strobe |
| rdAddr | input | 20 | Byte address of the read |
| arrayData | input | 8 | Data from the array |
| arrayRdEn | output | 1 | Read strobe passed to the array |
| rdData | output | 8 | Read data returned to the host |

## Verification
Requests go to the first and last byte of the sectors next to a locked sector. This shows whether the sector decode uses the right address bits and whether a lock leaks to neighbours. Each pin is pulled low on its own while requests target both sector 14 and sector 15. This separates the top-sector guard from the guard on the other sectors, and shows whether a lock bit is mistaken for a pin. The supply flags, a lock write while busy, the clear-status command colliding with a reject, and a reset in mid-operation are each tried separately. A read-locked sector is compared against an unlocked one to show that the zeroed data and the missing array strobe belong to the right sector.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic lockWe;   // load the addressed lock register
    logic errSet;   // a request is being rejected
    logic errClr;   // clear-status command
  } sgStrobe_t;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                resetN,
  input  sg_pkg::sgStrobe_t   strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [SECT_W-1:0]   lockWrSector,
  input  logic [1:0]          lockWrData,
  input  logic [SECT_W-1:0]   lockRdSector,
  output logic [1:0]          lockRdData,
  input  logic                rdValid,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   arrayData,
  output logic                arrayRdEn,
  output logic [DATA_W-1:0]   rdData,
  output logic                reqWrLocked,
  output logic                reqIsTop,
  output logic                protErr
);
  localparam int NUM_SECT = 1 << SECT_W;
  localparam logic [SECT_W-1:0] TOP_SECT = SECT_W'(NUM_SECT - 1);

  logic [1:0] lockBits [NUM_SECT];
  logic [SECT_W-1:0] reqSect, rdSect;
  logic rdLocked;

  genvar s;
  generate
    for (s = 0; s < NUM_SECT; s++) begin : gLock
      always_ff @(posedge clk or negedge resetN) begin
        if (!resetN)
          lockBits[s] <= '0;
        else if (strobe.lockWe && lockWrSector == SECT_W'(s))
          lockBits[s] <= lockWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN)
      protErr <= 1'b0;
    else if (strobe.errSet)
      protErr <= 1'b1;
    else if (strobe.errClr)
      protErr <= 1'b0;
  end

  always_comb begin
    reqSect     = reqAddr[ADDR_W-1 -: SECT_W];
    rdSect      = rdAddr[ADDR_W-1 -: SECT_W];
    reqWrLocked = lockBits[reqSect][0];
    reqIsTop    = (reqSect == TOP_SECT);
    rdLocked    = lockBits[rdSect][1];
    arrayRdEn   = rdValid && !rdLocked;
    rdData      = rdLocked ? '0 : arrayData;
    lockRdData  = lockBits[lockRdSector];
  end
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl (
  input  logic              clk,
  input  logic              resetN,
  input  logic              topLockN,
  input  logic              wpN,
  input  logic              vppLow,
  input  logic              vccLockout,
  input  logic              busy,
  input  logic              reqValid,
  input  logic              reqWrLocked,
  input  logic              reqIsTop,
  input  logic              lockWrEn,
  input  logic              clrStatus,
  output sg_pkg::sgStrobe_t strobe,
  output logic              reqGrant,
  output logic              reqReject
);
  logic supplyOk, pinOk, allowed;

  always_comb begin
    supplyOk      = !vppLow && !vccLockout;
    pinOk         = reqIsTop ? topLockN : wpN;
    allowed       = supplyOk && pinOk && !reqWrLocked;
    strobe.lockWe = lockWrEn && !busy;
    strobe.errSet = reqValid && !allowed;
    strobe.errClr = clrStatus;
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      reqGrant  <= 1'b0;
      reqReject <= 1'b0;
    end else begin
      reqGrant  <= reqValid && allowed;
      reqReject <= reqValid && !allowed;
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initN,
  input  logic              topLockN,
  input  logic              wpN,
  input  logic              vppLow,
  input  logic              vccLockout,
  input  logic              busy,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqGrant,
  output logic              reqReject,
  input  logic              lockWrEn,
  input  logic [SECT_W-1:0] lockWrSector,
  input  logic [1:0]        lockWrData,
  input  logic [SECT_W-1:0] lockRdSector,
  output logic [1:0]        lockRdData,
  input  logic              clrStatus,
  output logic              protErr,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic              arrayRdEn,
  output logic [DATA_W-1:0] rdData
);
  logic resetN;
  logic reqWrLocked, reqIsTop;
  sg_pkg::sgStrobe_t strobe;

  assign resetN = rstN && initN;

  sg_ctrl uCtrl (
    .clk(clk), .resetN(resetN), .topLockN(topLockN), .wpN(wpN),
    .vppLow(vppLow), .vccLockout(vccLockout), .busy(busy),
    .reqValid(reqValid), .reqWrLocked(reqWrLocked), .reqIsTop(reqIsTop),
    .lockWrEn(lockWrEn), .clrStatus(clrStatus), .strobe(strobe),
    .reqGrant(reqGrant), .reqReject(reqReject)
  );

  sg_datapath #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .resetN(resetN), .strobe(strobe), .reqAddr(reqAddr),
    .lockWrSector(lockWrSector), .lockWrData(lockWrData),
    .lockRdSector(lockRdSector), .lockRdData(lockRdData),
    .rdValid(rdValid), .rdAddr(rdAddr), .arrayData(arrayData),
    .arrayRdEn(arrayRdEn), .rdData(rdData),
    .reqWrLocked(reqWrLocked), .reqIsTop(reqIsTop), .protErr(protErr)
  );
endmodule

// File: rtl/sector_guard_checker.sv
module sector_guard_checker #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              initN,
  input logic              topLockN,
  input logic              wpN,
  input logic              vppLow,
  input logic              vccLockout,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqGrant,
  input logic              reqReject,
  input logic              clrStatus,
  input logic              protErr,
  input logic              rdValid,
  input logic              arrayRdEn,
  input logic [DATA_W-1:0] rdData
);
  localparam logic [SECT_W-1:0] TOP_SECT = '1;
  logic [SECT_W-1:0] reqSect;
  assign reqSect = reqAddr[ADDR_W-1 -: SECT_W];

  a_r8_single_answer: assert property (@(posedge clk) disable iff (!rstN || !initN)
    !(reqGrant && reqReject));

  a_r8_answer_follows: assert property (@(posedge clk) disable iff (!rstN || !initN)
    reqValid |=> (reqGrant || reqReject));

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN || !initN)
    !reqValid |=> !(reqGrant || reqReject));

  a_r2_top_pin: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (reqValid && !topLockN && reqSect == TOP_SECT) |=> reqReject);

  a_r3_wp_pin: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (reqValid && !wpN && reqSect != TOP_SECT) |=> reqReject);

  a_r5_supply: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (reqValid && (vppLow || vccLockout)) |=> reqReject);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (protErr && !clrStatus) |=> protErr);

  a_r9_set: assert property (@(posedge clk) disable iff (!rstN || !initN)
    reqReject |-> protErr);

  a_r10_read_zero: assert property (@(posedge clk) disable iff (!rstN || !initN)
    (rdValid && !arrayRdEn) |-> (rdData == '0));
endmodule

bind sector_guard sector_guard_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .initN(initN), .topLockN(topLockN), .wpN(wpN),
  .vppLow(vppLow), .vccLockout(vccLockout), .reqValid(reqValid),
  .reqAddr(reqAddr), .reqGrant(reqGrant), .reqReject(reqReject),
  .clrStatus(clrStatus), .protErr(protErr), .rdValid(rdValid),
  .arrayRdEn(arrayRdEn), .rdData(rdData)
);

// File: tb/sector_guard_test.sv
module sector_guard_test;
  logic clk = 1'b0;
  logic rstN, initN, topLockN, wpN, vppLow, vccLockout, busy;
  logic reqValid, lockWrEn, clrStatus, rdValid;
  logic [19:0] reqAddr, rdAddr;
  logic [3:0] lockWrSector, lockRdSector;
  logic [1:0] lockWrData, lockRdData;
  logic [7:0] arrayData, rdData;
  logic reqGrant, reqReject, protErr, arrayRdEn;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sector_guard uut (
    .clk(clk), .rstN(rstN), .initN(initN), .topLockN(topLockN), .wpN(wpN),
    .vppLow(vppLow), .vccLockout(vccLockout), .busy(busy),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqGrant(reqGrant),
    .reqReject(reqReject), .lockWrEn(lockWrEn), .lockWrSector(lockWrSector),
    .lockWrData(lockWrData), .lockRdSector(lockRdSector),
    .lockRdData(lockRdData), .clrStatus(clrStatus), .protErr(protErr),
    .rdValid(rdValid), .rdAddr(rdAddr), .arrayData(arrayData),
    .arrayRdEn(arrayRdEn), .rdData(rdData)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // request, then sample both answers in the next cycle
  task automatic request(string req, logic [19:0] addr, bit expGrant);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, $sformatf("answer @%05h", addr), {reqGrant, reqReject},
          expGrant ? 2'b10 : 2'b01);
  endtask

  task automatic lockWrite(logic [3:0] sect, logic [1:0] bits);
    @(negedge clk);
    lockWrEn = 1'b1; lockWrSector = sect; lockWrData = bits;
    @(negedge clk);
    lockWrEn = 1'b0;
  endtask

  task automatic readLock(string req, logic [3:0] sect, logic [1:0] exp);
    lockRdSector = sect; #1;
    check(req, $sformatf("lock bits s%0d", sect), lockRdData, exp);
  endtask

  task automatic testResetState();
    bit allClear = 1;
    @(negedge clk);
    check("R6", "idle answers", {reqGrant, reqReject}, 2'b00);
    check("R6", "protErr after reset", protErr, 0);
    for (int s = 0; s < 16; s++) begin
      lockRdSector = s[3:0]; #1;
      if (lockRdData !== 2'b00) allClear = 0;
    end
    check("R6", "all locks clear", allClear, 1);
  endtask

  task automatic testOpen();
    request("R8", 20'h00000, 1);
    request("R8", 20'h7ABCD, 1);
    request("R1", 20'hFFFFF, 1);
    @(negedge clk);
    check("R8", "no answer without request", {reqGrant, reqReject}, 2'b00);
    check("R9", "no error after grants", protErr, 0);
  endtask

  task automatic testSwLock();
    lockWrite(4'd5, 2'b01);
    readLock("R11", 4'd5, 2'b01);
    request("R4", 20'h50000, 0);
    check("R9", "protErr set by reject", protErr, 1);
    request("R1", 20'h5FFFF, 0);
    request("R1", 20'h4FFFF, 1);
    request("R1", 20'h60000, 1);
    check("R9", "protErr sticky across grants", protErr, 1);
  endtask

  task automatic testClear();
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0;
    check("R9", "protErr cleared", protErr, 0);
    @(negedge clk);
    clrStatus = 1'b1; reqValid = 1'b1; reqAddr = 20'h51234;
    @(negedge clk);
    clrStatus = 1'b0; reqValid = 1'b0;
    check("R9", "set wins over clear", protErr, 1);
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0;
  endtask

  task automatic testPins();
    topLockN = 1'b0;
    request("R2", 20'hF0000, 0);
    request("R2", 20'hEFFFF, 1);
    topLockN = 1'b1; wpN = 1'b0;
    request("R3", 20'hE0000, 0);
    request("R3", 20'h00010, 0);
    request("R3", 20'hF8000, 1);
    wpN = 1'b1;
    readLock("R4", 4'd5, 2'b01);
    readLock("R4", 4'd15, 2'b00);
    request("R4", 20'h5AAAA, 0);
    lockWrite(4'd15, 2'b01);
    request("R4", 20'hF0001, 0);
    lockWrite(4'd15, 2'b00);
    request("R4", 20'hF0001, 1);
  endtask

  task automatic testSupply();
    vppLow = 1'b1;
    request("R5", 20'h30000, 0);
    vppLow = 1'b0; vccLockout = 1'b1;
    request("R5", 20'hF0000, 0);
    vccLockout = 1'b0;
    request("R5", 20'h30000, 1);
  endtask

  task automatic testBusy();
    busy = 1'b1;
    lockWrite(4'd9, 2'b11);
    readLock("R7", 4'd9, 2'b00);
    busy = 1'b0;
    lockWrite(4'd9, 2'b10);
    readLock("R7", 4'd9, 2'b10);
  endtask

  task automatic testRead();
    rdValid = 1'b1; arrayData = 8'hA5;
    rdAddr = 20'h91234; #1;
    check("R10", "locked read data", rdData, 8'h00);
    check("R10", "locked read strobe", arrayRdEn, 0);
    rdAddr = 20'h81234; #1;
    check("R10", "open read data", rdData, 8'hA5);
    check("R10", "open read strobe", arrayRdEn, 1);
    rdValid = 1'b0;
    request("R10", 20'h90000, 1);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    initN = 1'b0; reqValid = 1'b1; reqAddr = 20'h50000;
    lockWrEn = 1'b1; lockWrSector = 4'd3; lockWrData = 2'b11;
    @(negedge clk);
    check("R6", "no answer in reset", {reqGrant, reqReject}, 2'b00);
    check("R6", "protErr held clear", protErr, 0);
    reqValid = 1'b0; lockWrEn = 1'b0;
    initN = 1'b1;
    readLock("R6", 4'd3, 2'b00);
    readLock("R6", 4'd5, 2'b00);
    readLock("R6", 4'd9, 2'b00);
    request("R6", 20'h50000, 1);
  endtask

  initial begin
    rstN = 1'b1; initN = 1'b1; topLockN = 1'b1; wpN = 1'b1;
    vppLow = 1'b0; vccLockout = 1'b0; busy = 1'b0;
    reqValid = 1'b0; reqAddr = '0; lockWrEn = 1'b0; lockWrSector = '0;
    lockWrData = '0; lockRdSector = '0; clrStatus = 1'b0;
    rdValid = 1'b0; rdAddr = '0; arrayData = '0;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testResetState();
    testOpen();
    testSwLock();
    testClear();
    testPins();
    testSupply();
    testBusy();
    testRead();
    testMidReset();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule